// File: doc/BRIEF.md
# USB Device State Tracker

This block holds the visible state of a USB device function and its bus address. Line events drive it: VBUS presence, a detected bus reset, a bus-idle level and a resume pulse. Decoded standard requests drive it too: SET_ADDRESS, SET_CONFIGURATION with its value, and SET_FEATURE(TEST_MODE) with its selector. From these it keeps a status byte in which exactly one lifecycle bit is set, plus a sticky test-mode bit. It also keeps the 7-bit function address and the 4-bit test selector.

Suspend is kept as a flag laid over the lifecycle state. While the flag is up, the status byte shows only the suspended bit, and the underlying state and address are frozen. On resume the frozen state shows again unchanged. Test mode stays set until VBUS goes away. The firmware or the packet engine reads the outputs directly.

Top module: `usb_dev_state_tracker`

## Requirements
- R1: While `rst_n` is low, `dev_status` is 8'h20 (only the attached bit), `dev_addr` is 0 and `test_sel` is 0.
- R2: Status bits are bit 6 test mode, bit 5 attached, bit 4 powered, bit 3 suspended, bit 2 default, bit 1 addressed and bit 0 configured. Bit 7 always reads 0. Exactly one of bits 5..0 is set at any time.
- R3: A clock edge that samples `vbus_valid` high while attached moves the device to powered.
- R4: A clock edge that samples `vbus_valid` low returns the device to attached from any state. The same edge clears suspend, test mode, the selector and the address.
- R5: With VBUS valid and the device past attached, a bus reset moves the device to default, clears the address and leaves suspend. Test mode and its selector are kept.
- R6: SET_ADDRESS is accepted in default or addressed. It moves the device to addressed and loads `set_addr_val`. In any other state it is ignored.
- R7: SET_CONFIGURATION is accepted in addressed or configured. A non-zero value moves the device to configured, and zero moves it to addressed. In any other state it is ignored.
- R8: When the device is past attached and not suspended, the IDLE_CYCLES-th consecutive edge that samples `bus_idle` high sets suspended. An edge that samples `bus_idle` low restarts the count.
- R9: While suspended, all requests are ignored and the address is held. A `bus_resume` pulse clears suspend and shows again the lifecycle state held before suspend.
- R10: SET_FEATURE(TEST_MODE) sets test mode and loads the selector. It is accepted only with a selector of 1 (J), 2 (K), 4 (SE0_NAK) or 8 (packet), only past attached, only when not suspended and only when not already in test mode. Other selector codes are ignored.
- R11: Events in one cycle resolve in this order: VBUS loss, power-up, bus reset, resume (when suspended), idle expiry, SET_ADDRESS, SET_CONFIGURATION, SET_FEATURE. A lower-ranked event in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vbus_valid | input | 1 | VBUS present |
| bus_reset | input | 1 | Bus reset detected, one-cycle pulse |
| bus_idle | input | 1 | Bus idle level |
| bus_resume | input | 1 | Resume signalling detected, one-cycle pulse |
| set_addr_stb | input | 1 | SET_ADDRESS decoded |
| set_addr_val | input | 7 | Address carried by SET_ADDRESS |
| set_cfg_stb | input | 1 | SET_CONFIGURATION decoded |
| set_cfg_val | input | 8 | Configuration value |
| set_test_stb | input | 1 | SET_FEATURE(TEST_MODE) decoded |
| set_test_sel | input | 4 | Test selector code |
| dev_status | output | 8 | Device status byte |
| dev_addr | output | 7 | Function address |
| test_sel | output | 4 | Active test selector |

## Verification
The events that can collide are idle expiry and a request strobe, and a bus reset and a resume pulse during suspend. The bench raises a SET_CONFIGURATION strobe on the exact edge where the idle count runs out. It expects the device to suspend and the configuration to stay unchanged. It then pulses reset and resume together while suspended and expects default with a cleared address. A behavioural model steps the same input stream every clock and compares all three outputs after every edge. This also covers stacked request strobes and VBUS loss during suspend.

// File: rtl/usb_dev_state_tracker.sv
module usb_dev_state_tracker #(
  parameter int IDLE_CYCLES = 150000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vbus_valid,
  input  logic       bus_reset,
  input  logic       bus_idle,
  input  logic       bus_resume,
  input  logic       set_addr_stb,
  input  logic [6:0] set_addr_val,
  input  logic       set_cfg_stb,
  input  logic [7:0] set_cfg_val,
  input  logic       set_test_stb,
  input  logic [3:0] set_test_sel,
  output logic [7:0] dev_status,
  output logic [6:0] dev_addr,
  output logic [3:0] test_sel
);

  localparam int CW = $clog2(IDLE_CYCLES + 1);

  typedef enum logic [2:0] {ST_ATT, ST_PWR, ST_DEF, ST_ADR, ST_CFG} life_t;

  life_t         life_q;
  logic          susp_q;
  logic          test_q;
  logic [3:0]    sel_q;
  logic [6:0]    addr_q;
  logic [CW-1:0] idle_q;

  logic idle_hit, sel_ok, addr_ok, cfg_ok;

  assign idle_hit = bus_idle && (idle_q == CW'(IDLE_CYCLES - 1));
  assign sel_ok   = $onehot(set_test_sel);
  assign addr_ok  = (life_q == ST_DEF) || (life_q == ST_ADR);
  assign cfg_ok   = (life_q == ST_ADR) || (life_q == ST_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      life_q <= ST_ATT;
      susp_q <= 1'b0;
      test_q <= 1'b0;
      sel_q  <= '0;
      addr_q <= '0;
      idle_q <= '0;
    end else if (!vbus_valid) begin
      life_q <= ST_ATT;
      susp_q <= 1'b0;
      test_q <= 1'b0;
      sel_q  <= '0;
      addr_q <= '0;
      idle_q <= '0;
    end else if (life_q == ST_ATT) begin
      life_q <= ST_PWR;
      idle_q <= '0;
    end else if (bus_reset) begin
      life_q <= ST_DEF;
      addr_q <= '0;
      susp_q <= 1'b0;
      idle_q <= '0;
    end else if (susp_q) begin
      if (bus_resume) susp_q <= 1'b0;
      idle_q <= '0;
    end else if (idle_hit) begin
      susp_q <= 1'b1;
      idle_q <= '0;
    end else begin
      idle_q <= bus_idle ? idle_q + CW'(1) : '0;
      if (set_addr_stb && addr_ok) begin
        life_q <= ST_ADR;
        addr_q <= set_addr_val;
      end else if (set_cfg_stb && cfg_ok) begin
        life_q <= (set_cfg_val != 8'd0) ? ST_CFG : ST_ADR;
      end else if (set_test_stb && !test_q && sel_ok) begin
        test_q <= 1'b1;
        sel_q  <= set_test_sel;
      end
    end
  end

  assign dev_status = {1'b0, test_q,
                       !susp_q && life_q == ST_ATT,
                       !susp_q && life_q == ST_PWR,
                       susp_q,
                       !susp_q && life_q == ST_DEF,
                       !susp_q && life_q == ST_ADR,
                       !susp_q && life_q == ST_CFG};
  assign dev_addr = addr_q;
  assign test_sel = sel_q;

  AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(dev_status[5:0])); // R2
  AST_VBUS_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    !vbus_valid |=> dev_status == 8'h20 && dev_addr == 7'd0 && test_sel == 4'd0); // R4
  AST_POWER_UP: assert property (@(posedge clk) disable iff (!rst_n)
    vbus_valid && dev_status[5] |=> dev_status[4]); // R3
  AST_BUS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    vbus_valid && bus_reset && !dev_status[5] |=> dev_status[2] && dev_addr == 7'd0); // R5
  AST_TEST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    vbus_valid && dev_status[6] |=> dev_status[6] && $stable(test_sel)); // R10
  AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    vbus_valid && !bus_reset && dev_status[3] |=> $stable(dev_addr)); // R9
  AST_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    vbus_valid && !bus_reset && dev_status[3] && bus_resume |=> !dev_status[3]); // R9

endmodule

// File: tb/tb_usb_dev_state_tracker.sv
module tb_usb_dev_state_tracker;
  localparam int IDLE = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vbus = 1'b0, brst = 1'b0, bidle = 1'b0, bres = 1'b0;
  logic sa = 1'b0, sc = 1'b0, st = 1'b0;
  logic [6:0] sav = '0;
  logic [7:0] scv = '0;
  logic [3:0] stv = '0;
  logic [7:0] status;
  logic [6:0] addr;
  logic [3:0] sel;

  int checks = 0, errors = 0;
  bit done = 0;

  // model: life 0 attached,1 powered,2 default,3 addressed,4 configured
  int m_life = 0, m_idle = 0, m_sel = 0, m_addr = 0;
  bit m_susp = 0, m_test = 0;

  always #10 clk = ~clk;

  usb_dev_state_tracker #(.IDLE_CYCLES(IDLE)) dut (
    .clk(clk), .rst_n(rst_n), .vbus_valid(vbus), .bus_reset(brst),
    .bus_idle(bidle), .bus_resume(bres), .set_addr_stb(sa),
    .set_addr_val(sav), .set_cfg_stb(sc), .set_cfg_val(scv),
    .set_test_stb(st), .set_test_sel(stv), .dev_status(status),
    .dev_addr(addr), .test_sel(sel));

  function automatic logic [7:0] exp_status();
    logic [7:0] s;
    s = 8'h00;
    s[6] = m_test;
    if (m_susp) s[3] = 1'b1;
    else case (m_life)
      0: s[5] = 1'b1;
      1: s[4] = 1'b1;
      2: s[2] = 1'b1;
      3: s[1] = 1'b1;
      default: s[0] = 1'b1;
    endcase
    return s;
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (status !== exp_status() || addr !== 7'(m_addr) || sel !== 4'(m_sel)) begin
      errors++;
      $display("FAIL %s: status %h addr %0d sel %0d, expected status %h addr %0d sel %0d",
               tag, status, addr, sel, exp_status(), m_addr, m_sel);
    end
  endtask

  task automatic model_edge();
    bit sel_good;
    sel_good = (stv == 1 || stv == 2 || stv == 4 || stv == 8);
    if (!vbus) begin
      m_life = 0; m_susp = 0; m_test = 0; m_sel = 0; m_addr = 0; m_idle = 0;
    end else if (m_life == 0) begin
      m_life = 1; m_idle = 0;
    end else if (brst) begin
      m_life = 2; m_addr = 0; m_susp = 0; m_idle = 0;
    end else if (m_susp) begin
      if (bres) m_susp = 0;
      m_idle = 0;
    end else if (bidle && m_idle + 1 == IDLE) begin
      m_susp = 1; m_idle = 0;
    end else begin
      m_idle = bidle ? m_idle + 1 : 0;
      if (sa && (m_life == 2 || m_life == 3)) begin
        m_life = 3; m_addr = sav;
      end else if (sc && (m_life == 3 || m_life == 4)) begin
        m_life = (scv != 0) ? 4 : 3;
      end else if (st && !m_test && sel_good) begin
        m_test = 1; m_sel = stv;
      end
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
    brst = 0; bres = 0; sa = 0; sc = 0; st = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    compare("R1 reset state");
    rst_n = 1'b1;
    step("R4 no vbus stays attached");
    vbus = 1; step("R3 power up");
    step("R2 powered holds");
    sa = 1; sav = 7'd9; step("R6 address ignored when powered");
    sc = 1; scv = 8'd1; step("R7 config ignored when powered");
    brst = 1; step("R5 bus reset to default");
    sc = 1; scv = 8'd2; step("R7 config ignored in default");
    sa = 1; sav = 7'd42; step("R6 set address");
    sc = 1; scv = 8'd0; step("R7 config zero stays addressed");
    sc = 1; scv = 8'd5; step("R7 config nonzero");
    sa = 1; sav = 7'd3; step("R6 address ignored when configured");
    sc = 1; scv = 8'd0; step("R7 config zero back to addressed");
    sa = 1; sav = 7'd17; step("R6 readdress");
    sc = 1; scv = 8'd3; step("R7 configure again");
    bidle = 1;
    for (int i = 0; i < 10; i++) step("R8 partial idle");
    bidle = 0; step("R8 activity restarts count");
    bidle = 1;
    for (int i = 0; i < IDLE - 1; i++) step("R8 idle counting");
    sc = 1; scv = 8'd0; step("R11 idle expiry beats config");
    sa = 1; sav = 7'd5; step("R9 address ignored while suspended");
    st = 1; stv = 4'd2; step("R9 test ignored while suspended");
    bidle = 0;
    bres = 1; step("R9 resume restores configured");
    step("R9 configured after resume");
    bidle = 1;
    for (int i = 0; i < IDLE; i++) step("R8 idle to suspend");
    brst = 1; bres = 1; step("R11 reset beats resume");
    bidle = 0;
    st = 1; stv = 4'd3; step("R10 reserved selector ignored");
    sa = 1; sav = 7'd33; sc = 1; scv = 8'd1; st = 1; stv = 4'd1;
    step("R11 address beats config and test");
    sc = 1; scv = 8'd2; st = 1; stv = 4'd4; step("R11 config beats test");
    st = 1; stv = 4'd4; step("R10 enter test mode");
    st = 1; stv = 4'd8; step("R10 second selector ignored");
    brst = 1; step("R5 bus reset keeps test mode");
    sa = 1; sav = 7'd11; step("R6 address in test mode");
    bidle = 1;
    for (int i = 0; i < IDLE; i++) step("R8 suspend in test mode");
    vbus = 0; step("R4 vbus loss while suspended");
    bidle = 0;
    step("R4 attached holds");
    vbus = 1; step("R3 power up again");
    brst = 1; step("R5 reset after repower");
    st = 1; stv = 4'd8; step("R10 test packet after repower");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule